// File: doc/BRIEF.md
# SPI EEPROM Page Program Sequencer

This block writes a run of bytes into a serial EEPROM that is organised in 64-byte pages. The caller gives a start address, a byte count and a mode bit, then pulses `start`. In normal mode the data bytes come from a valid/ready byte stream. In erase mode the stream is never touched and every byte written is 0xFF. The block drives the four SPI wires itself in clock mode 0 and raises `done` when the job is finished, together with `timeout` when the device stayed busy for too long.

The job runs as a series of separate chip-select transactions. The block first waits for the device to be idle by reading its status register. For each page it then sets the write-enable latch, sends a program command with a 16-bit address and the bytes that fit before the next page boundary, and waits for the device to be idle again. A job that crosses page boundaries is split into several program bursts without any help from the caller. Chip select is held high for a minimum number of clocks between any two transactions.

Top module: `eeprom_page_writer`

## Requirements
- R1: After reset `cs_n` is 1, and `sck`, `busy`, `done`, `timeout` and `in_ready` are 0.
- R2: The first transaction of every job is a status read (opcode 0x05 followed by one dummy byte). The block repeats it until status bit 0 (write in progress) reads 0, and only then issues any write-enable.
- R3: Each page is written as two transactions. The first is a write-enable transaction holding the single byte 0x06. The second is a program transaction holding 0x02, the address high byte, the address low byte and the data bytes. Every byte is sent MSB first.
- R4: A program burst never crosses a 64-byte boundary. It ends after the byte at an address whose low 6 bits are all ones, or after the last byte of the job. The number of program transactions equals the number of pages the job touches, and each burst carries the address of its first byte.
- R5: After every program burst the block polls status until bit 0 reads 0. `done` follows the final ready status read, with `cs_n` already high.
- R6: If POLL_LIMIT status reads in a row all return bit 0 set, the block stops without a further transaction and pulses `timeout` together with `done`.
- R7: In erase mode every data byte sent is 0xFF and `in_ready` stays 0 for the whole job.
- R8: SPI mode 0 is used. `sck` is 0 while `cs_n` is 1, and `mosi` changes only while `sck` is 0. `miso` is sampled at the end of each high phase of `sck`, and each bit phase lasts CLK_DIV clocks.
- R9: `cs_n` stays high for at least CS_GAP clocks between any two transactions.
- R10: A stream byte is consumed only in a cycle with both `in_valid` and `in_ready` high. Gaps in `in_valid` delay the job but do not change the data written, and the job consumes exactly `length` bytes.
- R11: A `start` pulse while `busy` is 1 is ignored.
- R12: A job of length 0 performs only the initial status polling and then finishes, with no write-enable and no program transaction.
- R13: `done` is high for exactly one clock, and `busy` is 0 in the clock that follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Starts a job when the block is idle |
| start_addr | input | 16 | Device address of the first byte |
| length | input | LEN_W | Number of bytes to write |
| erase | input | 1 | 1: write 0xFF bytes and ignore the stream |
| in_data | input | 8 | Stream byte |
| in_valid | input | 1 | Stream byte present |
| in_ready | output | 1 | Block takes the stream byte this cycle |
| sck | output | 1 | SPI serial clock |
| cs_n | output | 1 | SPI chip select, active low |
| mosi | output | 1 | SPI data to the device |
| miso | input | 1 | SPI data from the device |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-clock pulse at the end of a job |
| timeout | output | 1 | Pulses with `done` when status polling gave up |

## Verification
The results of this block arrive at very different times. A bit on `mosi` takes 2·CLK_DIV clocks, and a whole job takes thousands of clocks. The bench therefore never checks an output at a fixed delay after `start`. It waits on falling clock edges for `done`, checks `timeout` and `cs_n` in that same cycle, and checks `done` and `busy` one clock later. The device model decodes the SPI wires one clock after each edge of `sck` and `cs_n`, so the bench waits a few clocks after `done` before it compares the transaction log, the page contents and the stream byte count with values it computes itself from the job parameters.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    localparam int ADDR_W = 16;

    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_RDSR   = 8'h05;
    localparam logic [7:0] FILL_BYTE = 8'hFF;
    localparam logic [7:0] DUMMY     = 8'h00;
    localparam int         WIP_BIT   = 0;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_GAP,
        ST_POLL_OP,
        ST_POLL_RD,
        ST_WREN,
        ST_PROG_OP,
        ST_ADDR_HI,
        ST_ADDR_LO,
        ST_DATA,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              erase;
    } job_t;

    function automatic logic drives_bus(seq_state_e s);
        return (s == ST_POLL_OP) || (s == ST_POLL_RD) || (s == ST_WREN) ||
               (s == ST_PROG_OP) || (s == ST_ADDR_HI) || (s == ST_ADDR_LO) ||
               (s == ST_DATA);
    endfunction

endpackage

// File: rtl/eepw_shifter.sv
module eepw_shifter #(
    parameter int CLK_DIV = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic       busy,
    output logic       fin,
    output logic [7:0] rx
);
    localparam int CNT_W = $clog2(CLK_DIV + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CLK_DIV - 1);

    logic [7:0]       sh_q;
    logic [7:0]       rx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [2:0]       bit_q;
    logic             high_q;
    logic             busy_q;
    logic             fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q   <= '0;
            rx_q   <= '0;
            cnt_q  <= '0;
            bit_q  <= '0;
            high_q <= 1'b0;
            busy_q <= 1'b0;
            fin_q  <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (!busy_q) begin
                if (go) begin
                    sh_q   <= tx;
                    busy_q <= 1'b1;
                    cnt_q  <= '0;
                    bit_q  <= '0;
                    high_q <= 1'b0;
                end
            end else if (cnt_q == CNT_LAST) begin
                cnt_q <= '0;
                if (!high_q) begin
                    high_q <= 1'b1;
                end else begin
                    high_q <= 1'b0;
                    rx_q   <= {rx_q[6:0], miso};
                    sh_q   <= {sh_q[6:0], 1'b0};
                    bit_q  <= bit_q + 3'd1;
                    if (bit_q == 3'd7) begin
                        busy_q <= 1'b0;
                        fin_q  <= 1'b1;
                    end
                end
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign sck  = busy_q & high_q;
    assign mosi = sh_q[7];
    assign busy = busy_q;
    assign fin  = fin_q;
    assign rx   = rx_q;

    // R8: a byte is only launched into an idle shifter
    p_go_idle_r8: assert property (@(posedge clk) disable iff (rst)
        go |-> !busy_q);

endmodule

// File: rtl/eepw_ctrl.sv
module eepw_ctrl
    import eepw_pkg::*;
#(
    parameter int LEN_W      = 16,
    parameter int PAGE_BITS  = 6,
    parameter int POLL_LIMIT = 1000,
    parameter int CS_GAP     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [LEN_W-1:0]  length,
    input  logic              erase,
    input  logic [7:0]        in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              sh_go,
    output logic [7:0]        sh_tx,
    input  logic              sh_busy,
    input  logic              sh_fin,
    input  logic [7:0]        sh_rx,
    output logic              cs_n,
    output logic              busy,
    output logic              done,
    output logic              timeout
);
    localparam int GAP_W = $clog2(CS_GAP + 1);
    localparam int TRY_W = $clog2(POLL_LIMIT + 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(CS_GAP - 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(POLL_LIMIT - 1);

    seq_state_e       state_q;
    seq_state_e       after_gap_q;
    logic [GAP_W-1:0] gap_q;
    logic [TRY_W-1:0] tries_q;
    job_t             job_q;
    logic [LEN_W-1:0] left_q;
    logic             inflight_q;
    logic             to_q;

    logic on_bus;
    logic byte_ok;
    logic page_end;
    logic last_byte;

    assign on_bus    = drives_bus(state_q);
    assign byte_ok   = (state_q != ST_DATA) || job_q.erase || in_valid;
    assign page_end  = &job_q.addr[PAGE_BITS-1:0];
    assign last_byte = (left_q == LEN_W'(1));

    assign sh_go    = on_bus && !inflight_q && byte_ok;
    assign in_ready = (state_q == ST_DATA) && !inflight_q && !job_q.erase;
    assign cs_n     = !on_bus;
    assign busy     = (state_q != ST_IDLE);
    assign done     = (state_q == ST_DONE);
    assign timeout  = (state_q == ST_DONE) && to_q;

    always_comb begin
        case (state_q)
            ST_POLL_OP: sh_tx = OP_RDSR;
            ST_WREN:    sh_tx = OP_WREN;
            ST_PROG_OP: sh_tx = OP_PROG;
            ST_ADDR_HI: sh_tx = job_q.addr[15:8];
            ST_ADDR_LO: sh_tx = job_q.addr[7:0];
            ST_DATA:    sh_tx = job_q.erase ? FILL_BYTE : in_data;
            default:    sh_tx = DUMMY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            after_gap_q <= ST_POLL_OP;
            gap_q       <= '0;
            tries_q     <= '0;
            job_q       <= '0;
            left_q      <= '0;
            inflight_q  <= 1'b0;
            to_q        <= 1'b0;
        end else begin
            if (sh_go) begin
                inflight_q <= 1'b1;
            end else if (sh_fin) begin
                inflight_q <= 1'b0;
            end
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        job_q.addr  <= start_addr;
                        job_q.erase <= erase;
                        left_q      <= length;
                        tries_q     <= '0;
                        to_q        <= 1'b0;
                        gap_q       <= '0;
                        after_gap_q <= ST_POLL_OP;
                        state_q     <= ST_GAP;
                    end
                end
                ST_GAP: begin
                    if (gap_q == GAP_LAST) begin
                        gap_q   <= '0;
                        state_q <= after_gap_q;
                    end else begin
                        gap_q <= gap_q + 1'b1;
                    end
                end
                ST_POLL_OP: if (sh_fin) state_q <= ST_POLL_RD;
                ST_POLL_RD: begin
                    if (sh_fin) begin
                        if (!sh_rx[WIP_BIT]) begin
                            tries_q <= '0;
                            if (left_q == '0) begin
                                state_q <= ST_DONE;
                            end else begin
                                after_gap_q <= ST_WREN;
                                state_q     <= ST_GAP;
                            end
                        end else if (tries_q == TRY_LAST) begin
                            to_q    <= 1'b1;
                            state_q <= ST_DONE;
                        end else begin
                            tries_q     <= tries_q + 1'b1;
                            after_gap_q <= ST_POLL_OP;
                            state_q     <= ST_GAP;
                        end
                    end
                end
                ST_WREN: begin
                    if (sh_fin) begin
                        after_gap_q <= ST_PROG_OP;
                        state_q     <= ST_GAP;
                    end
                end
                ST_PROG_OP: if (sh_fin) state_q <= ST_ADDR_HI;
                ST_ADDR_HI: if (sh_fin) state_q <= ST_ADDR_LO;
                ST_ADDR_LO: if (sh_fin) state_q <= ST_DATA;
                ST_DATA: begin
                    if (sh_fin) begin
                        job_q.addr <= job_q.addr + 1'b1;
                        left_q     <= left_q - 1'b1;
                        if (last_byte || page_end) begin
                            after_gap_q <= ST_POLL_OP;
                            state_q     <= ST_GAP;
                        end
                    end
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R10: an accepted stream byte goes straight into the shifter
    p_accept_shifts_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> sh_busy);

    // R11: a start during a job leaves the latched mode untouched
    p_start_ignored_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(job_q.erase));

endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer
    import eepw_pkg::*;
#(
    parameter int CLK_DIV    = 4,
    parameter int LEN_W      = 16,
    parameter int PAGE_BYTES = 64,
    parameter int POLL_LIMIT = 1000,
    parameter int CS_GAP     = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [15:0]      start_addr,
    input  logic [LEN_W-1:0] length,
    input  logic             erase,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso,
    output logic             busy,
    output logic             done,
    output logic             timeout
);
    localparam int PAGE_BITS = $clog2(PAGE_BYTES);
    localparam int GAP_W     = $clog2(CS_GAP + 1);

    logic       sh_go;
    logic [7:0] sh_tx;
    logic       sh_busy;
    logic       sh_fin;
    logic [7:0] sh_rx;

    eepw_ctrl #(
        .LEN_W      (LEN_W),
        .PAGE_BITS  (PAGE_BITS),
        .POLL_LIMIT (POLL_LIMIT),
        .CS_GAP     (CS_GAP)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_addr (start_addr),
        .length     (length),
        .erase      (erase),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .sh_go      (sh_go),
        .sh_tx      (sh_tx),
        .sh_busy    (sh_busy),
        .sh_fin     (sh_fin),
        .sh_rx      (sh_rx),
        .cs_n       (cs_n),
        .busy       (busy),
        .done       (done),
        .timeout    (timeout)
    );

    eepw_shifter #(
        .CLK_DIV (CLK_DIV)
    ) u_shift (
        .clk  (clk),
        .rst  (rst),
        .go   (sh_go),
        .tx   (sh_tx),
        .miso (miso),
        .sck  (sck),
        .mosi (mosi),
        .busy (sh_busy),
        .fin  (sh_fin),
        .rx   (sh_rx)
    );

    // run length of chip select high, saturating at CS_GAP
    logic [GAP_W-1:0] cs_hi_run;
    always_ff @(posedge clk) begin
        if (rst) begin
            cs_hi_run <= '0;
        end else if (!cs_n) begin
            cs_hi_run <= '0;
        end else if (cs_hi_run != GAP_W'(CS_GAP)) begin
            cs_hi_run <= cs_hi_run + 1'b1;
        end
    end

    p_sck_idle_r8: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    p_mosi_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    p_cs_gap_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(cs_n) |-> (cs_hi_run >= GAP_W'(CS_GAP)));

    p_to_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        timeout |=> cs_n);

    p_done_pulse_r13: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

endmodule

// File: tb/eeprom_page_writer_test.sv
module eeprom_page_writer_test;

    localparam int DIV   = 2;
    localparam int GAP   = 3;
    localparam int LIMIT = 6;
    localparam int NVEC  = 6;

    // [39:24] address, [23:8] length, [7] erase, [6] stall, [3:0] busy polls
    localparam logic [39:0] VEC [NVEC] = '{
        {16'h0010, 16'd8,   1'b0, 1'b0, 2'b00, 4'd1},
        {16'h003C, 16'd10,  1'b0, 1'b0, 2'b00, 4'd0},
        {16'h0040, 16'd64,  1'b0, 1'b1, 2'b00, 4'd2},
        {16'h0025, 16'd150, 1'b1, 1'b0, 2'b00, 4'd1},
        {16'h00FF, 16'd1,   1'b0, 1'b1, 2'b00, 4'd0},
        {16'h0080, 16'd0,   1'b0, 1'b0, 2'b00, 4'd1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] start_addr = '0;
    logic [15:0] length = '0;
    logic        erase = 1'b0;
    logic [7:0]  in_data;
    logic        in_valid;
    logic        in_ready;
    logic        sck, cs_n, mosi, busy, done, timeout;
    logic        miso = 1'b0;

    always #4 clk = ~clk;

    eeprom_page_writer #(
        .CLK_DIV(DIV), .LEN_W(16), .PAGE_BYTES(64), .POLL_LIMIT(LIMIT), .CS_GAP(GAP)
    ) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr), .length(length),
        .erase(erase), .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso), .busy(busy), .done(done),
        .timeout(timeout)
    );

    int checks = 0;
    int errors = 0;

    // ---------------- stream source ----------------
    logic [15:0] cur_addr = '0;
    logic        stall = 1'b0;
    logic        idx_clr = 1'b0;
    int          idx = 0;
    logic [7:0]  cyc = '0;

    function automatic logic [7:0] pat(int i, logic [15:0] a);
        return 8'(i * 7) + a[7:0] + 8'h31;
    endfunction

    assign in_data  = pat(idx, cur_addr);
    assign in_valid = !stall || cyc[1];

    always @(posedge clk) begin
        cyc <= cyc + 8'd1;
        if (idx_clr) idx <= 0;
        else if (in_valid && in_ready) idx <= idx + 1;
    end

    // ---------------- device model ----------------
    logic       mclr = 1'b0;
    int         cfg_busy = 0;
    logic [7:0] mem [256];
    int         txop [64];
    int         txlen [64];
    int         txadr [64];
    int         ntx, busy_left, mdl_err, gap_min, hi_run, nb, ob;
    logic       wel, sck_q, cs_q, mosi_q;
    logic [7:0] sh, op, ahi, alo, stat;

    always @(posedge clk) begin
        if (mclr) begin
            for (int i = 0; i < 256; i++) mem[i] = 8'h00;
            ntx = 0; busy_left = cfg_busy; wel = 1'b0; mdl_err = 0;
            gap_min = 1000; hi_run = 0; nb = 0; ob = 0;
            sck_q = 1'b0; cs_q = 1'b1; mosi_q = 1'b0; op = 8'h00;
            miso <= 1'b0;
        end else begin
            if (cs_q && !cs_n) begin
                if (ntx > 0 && hi_run < gap_min) gap_min = hi_run;
                hi_run = 0; nb = 0; ob = 0; op = 8'h00;
                stat = (busy_left > 0) ? 8'h01 : 8'h00;
            end
            if (cs_n) hi_run++;
            if (cs_n && sck) mdl_err++;
            if (sck && sck_q && mosi != mosi_q) mdl_err++;
            if (!cs_n && sck && !sck_q) begin
                sh = {sh[6:0], mosi};
                nb++;
                if (nb % 8 == 0) begin
                    int b;
                    b = nb / 8 - 1;
                    if (b == 0) begin
                        op = sh;
                        if (sh == 8'h02 && !wel) mdl_err++;
                    end else if (b == 1) ahi = sh;
                    else if (b == 2) alo = sh;
                    else if (op == 8'h02) begin
                        int k;
                        k = b - 3;
                        if (int'(alo[5:0]) + k > 63) mdl_err++;
                        mem[{alo[7:6], 6'(int'(alo[5:0]) + k)}] = sh;
                    end
                end
            end
            if (!cs_n && !sck && sck_q) begin
                ob++;
                if (ob >= 8 && ob < 16) miso <= stat[15 - ob];
                else miso <= 1'b0;
            end
            if (!cs_q && cs_n) begin
                if (ntx < 64) begin
                    txop[ntx] = int'(op); txlen[ntx] = nb / 8; txadr[ntx] = int'({ahi, alo});
                end
                ntx++;
                if (nb % 8 != 0) mdl_err++;
                if (op == 8'h06) wel = 1'b1;
                else if (op == 8'h02) begin wel = 1'b0; busy_left = cfg_busy; end
                else if (op == 8'h05 && busy_left > 0) busy_left--;
            end
            sck_q = sck; cs_q = cs_n; mosi_q = mosi;
        end
    end

    // ---------------- check helpers ----------------
    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic run_job(input logic [15:0] a, input int n, input logic er, input logic st,
                           input int bz, input logic ex_to, input logic inject);
        int e_ops [64];
        int e_len [64];
        int e_adr [64];
        int k, pa, rem, c, bad, pages, nprog, tail, wait_n;
        logic got_to, got_cs, seen;
        cfg_busy = bz; cur_addr = a; stall = st;
        mclr = 1'b1; idx_clr = 1'b1;
        @(negedge clk); @(negedge clk);
        mclr = 1'b0; idx_clr = 1'b0;
        start_addr = a; length = 16'(n); erase = er; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            repeat (150) @(negedge clk);
            start_addr = 16'h0090; length = 16'd5; erase = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        seen = 1'b0; wait_n = 0; got_to = 1'b0; got_cs = 1'b0;
        while (!seen && wait_n < 40000) begin
            if (done) begin seen = 1'b1; got_to = timeout; got_cs = cs_n; end
            else begin @(negedge clk); wait_n++; end
        end
        chk(seen, "R5 done seen", int'(seen), 1);
        @(negedge clk);
        chk(!done && !busy, "R13 done single pulse", int'({done, busy}), 0);
        repeat (4) @(negedge clk);

        // expected transaction list
        k = 0; pages = 0;
        if (ex_to) begin
            for (int i = 0; i < LIMIT; i++) begin e_ops[k] = 5; k++; end
        end else begin
            for (int i = 0; i <= bz; i++) begin e_ops[k] = 5; k++; end
            pa = int'(a); rem = n;
            while (rem > 0) begin
                c = 64 - (pa % 64);
                if (rem < c) c = rem;
                e_ops[k] = 6; k++;
                e_ops[k] = 2; e_len[k] = 3 + c; e_adr[k] = pa; k++;
                for (int i = 0; i <= bz; i++) begin e_ops[k] = 5; k++; end
                pa += c; rem -= c; pages++;
            end
        end
        chk(ntx == k, "R3 transaction count", ntx, k);
        chk(txop[0] == 5, "R2 first transaction is status read", txop[0], 5);
        bad = 0; nprog = 0;
        for (int i = 0; i < k && i < ntx && i < 64; i++) begin
            if (txop[i] != e_ops[i]) bad++;
            if (txop[i] == 5 && txlen[i] != 2) bad++;
            if (txop[i] == 6 && txlen[i] != 1) bad++;
        end
        chk(bad == 0, "R3 opcode order", bad, 0);
        bad = 0;
        for (int i = 0; i < k && i < ntx && i < 64; i++) begin
            if (e_ops[i] == 2) begin
                nprog++;
                if (txlen[i] != e_len[i] || txadr[i] != e_adr[i]) bad++;
            end
        end
        chk(bad == 0 && nprog == pages, "R4 page bursts", bad, 0);
        tail = 0;
        for (int i = ntx - 1; i >= 0 && i < 64 && txop[i] == 5; i--) tail++;
        if (!ex_to) chk(tail == bz + 1 && got_cs, "R5 final polling", tail, bz + 1);
        chk(got_to == ex_to, "R6 timeout flag", int'(got_to), int'(ex_to));
        chk(mdl_err == 0, "R8 bus protocol", mdl_err, 0);
        if (ntx > 1) chk(gap_min >= GAP, "R9 chip select gap", gap_min, GAP);
        if (er) chk(idx == 0, "R7 stream untouched in erase", idx, 0);
        else if (!ex_to) chk(idx == n, "R10 bytes consumed", idx, n);
        bad = 0;
        if (!ex_to) begin
            for (int i = 0; i < n; i++)
                if (mem[(int'(a) + i) % 256] != (er ? 8'hFF : pat(i, a))) bad++;
        end else begin
            for (int i = 0; i < n; i++)
                if (mem[(int'(a) + i) % 256] != 8'h00) bad++;
        end
        if (mem[(int'(a) + 255) % 256] != 8'h00) bad++;
        if (mem[(int'(a) + n) % 256] != 8'h00) bad++;
        chk(bad == 0, er ? "R7 erase contents" : "R3 page contents", bad, 0);
        if (inject) begin
            bad = 0;
            for (int i = 0; i < 5; i++) if (mem[16'h90 + i] != 8'h00) bad++;
            chk(bad == 0, "R11 start while busy ignored", bad, 0);
        end
        if (n == 0) chk(ntx == bz + 1, "R12 empty job polls only", ntx, bz + 1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        mclr = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        mclr = 1'b0;
        @(negedge clk);
        chk(cs_n && !sck && !busy && !done && !timeout && !in_ready, "R1 reset state",
            int'({cs_n, sck, busy, done, timeout, in_ready}), 32);

        for (int v = 0; v < NVEC; v++) begin
            run_job(VEC[v][39:24], int'(VEC[v][23:8]), VEC[v][7], VEC[v][6],
                    int'(VEC[v][3:0]), 1'b0, 1'b0);
        end

        // R6: device never becomes ready
        run_job(16'h0020, 4, 1'b0, 1'b0, 200, 1'b1, 1'b0);
        // R11: second start during a job
        run_job(16'h0010, 3, 1'b0, 1'b0, 0, 1'b0, 1'b1);
        // R10 and R4: stalled stream across a boundary
        run_job(16'h007E, 5, 1'b0, 1'b1, 1, 1'b0, 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule